// File: doc/BRIEF.md
# Internal Data Memory Address Mapper

This block sits between the operand-access logic of an 8-bit microcontroller core and its on-chip data storage. Each request carries an access kind and one 8-bit address or register index. The block turns the request into one physical target: a byte of the 256-byte internal RAM, an address on the special-function-register (SFR) bus, or a single bit inside one of those bytes. The same 8-bit value reaches different storage depending on the kind. A register index is offset by the active bank. A direct address above 7Fh selects an SFR. An indirect address always lands in RAM. A bit address selects either a byte in the bit-addressable RAM window or an SFR whose address is a multiple of 8.

The block owns two pieces of core context. The first is the two-bit register bank select, which the program status word owner loads through a dedicated strobe. The second is the stack pointer, which also answers direct accesses at its SFR address. Both RAM and the SFR bus are read asynchronously by the block. A bit write therefore reads the containing byte and writes it back with one bit changed, all in the same cycle. Push and pop requests use the stack pointer as the address and update it at the clock edge.

Top module: `idm_mapper`

## Requirements
- R1: After reset the stack pointer output is 07h and the bank output is 0. With no request, no RAM or SFR strobe is active.
- R2: Kind 0 (register) reaches RAM byte bank*8 + index[2:0]. A pulse on bank_load makes bank_val the active bank from the next cycle on.
- R3: Kind 1 (direct) with an address of 00h to 7Fh reaches the RAM byte with the same address, and no SFR strobe is active.
- R4: Kind 1 (direct) with an address of 80h to FFh, other than 81h, drives that address on the SFR bus with no RAM strobe. A write carries req_wdata, and a read returns sfr_rdata.
- R5: Kind 1 (direct) at 81h reaches the stack pointer and no external strobe. A read returns the pointer, and a write loads it at the clock edge.
- R6: Kind 2 (indirect) reaches the RAM byte with the same address for every value 00h to FFh, and never the SFR bus.
- R7: Kind 3 (bit) with an address b below 80h selects RAM byte 20h + b[6:3] and bit b[2:0]. A read returns that bit in rd_data[0], with the other bits of rd_data zero.
- R8: A bit write asserts read and write strobes of one target in the same cycle. It writes back the containing byte with only the selected bit replaced by req_wdata[0].
- R9: Kind 3 (bit) with an address b of 80h or above targets SFR address b with bits [2:0] cleared. Bit reads and writes work as in R7 and R8, on sfr_rdata.
- R10: Kind 4 (push) writes req_wdata to RAM byte sp+1, modulo 256, and the stack pointer becomes sp+1.
- R11: Kind 5 (pop) reads RAM byte sp into rd_data, and the stack pointer becomes sp-1.
- R12: Kinds 6 and 7, and any cycle with req_valid low, assert no strobe and leave the stack pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Access kind (0 reg, 1 direct, 2 indirect, 3 bit, 4 push, 5 pop) |
| req_addr | input | 8 | Address, register index or bit address |
| req_write | input | 1 | Write request (ignored for push and pop) |
| req_wdata | input | 8 | Write byte; bit 0 is the value for bit writes |
| bank_load | input | 1 | Load the register bank select |
| bank_val | input | 2 | New register bank |
| rd_data | output | 8 | Read result of the current request |
| ram_addr | output | 8 | Internal RAM byte address |
| ram_re | output | 1 | Internal RAM read strobe |
| ram_we | output | 1 | Internal RAM write strobe |
| ram_wdata | output | 8 | Internal RAM write byte |
| ram_rdata | input | 8 | Internal RAM read byte (asynchronous) |
| sfr_addr | output | 8 | SFR bus address |
| sfr_re | output | 1 | SFR read strobe |
| sfr_we | output | 1 | SFR write strobe |
| sfr_wdata | output | 8 | SFR write byte |
| sfr_rdata | input | 8 | SFR read byte (asynchronous) |
| sp | output | 8 | Stack pointer |
| bank | output | 2 | Active register bank |

## Verification
Address 90h is sent as a direct access and again as an indirect access. The first must appear on the SFR bus and the second in RAM, which separates the two high-half paths. A register index is read under bank 3 and written under bank 0, which shows that the bank offset is applied. Bit accesses are tried below and above 80h, and they set and clear bits in bytes that already hold other ones. This exposes a wrong byte offset, a wrong bit position or a merge that disturbs neighbouring bits. Pushes, a pop and a push from FFh check the order of pre-increment and post-decrement and the wrap of the stack pointer. Direct accesses to 81h and the unused kinds show that these requests reach no external strobe.

// File: rtl/idm_pkg.sv
package idm_pkg;

    typedef enum logic [2:0] {
        K_REG  = 3'd0,
        K_DIR  = 3'd1,
        K_IND  = 3'd2,
        K_BIT  = 3'd3,
        K_PUSH = 3'd4,
        K_POP  = 3'd5,
        K_RSV6 = 3'd6,
        K_RSV7 = 3'd7
    } kind_e;

    typedef enum logic [1:0] {
        T_NONE = 2'd0,
        T_RAM  = 2'd1,
        T_SFR  = 2'd2,
        T_SP   = 2'd3
    } target_e;

endpackage

// File: rtl/idm_decode.sv
module idm_decode
    import idm_pkg::*;
#(
    parameter int          AW       = 8,
    parameter int          BANK_W   = 2,
    parameter int          REGIDX_W = 3,
    parameter logic [7:0]  BIT_BASE = 8'h20,
    parameter logic [7:0]  SP_SFR   = 8'h81
) (
    input  logic                req_valid,
    input  logic [2:0]          req_kind,
    input  logic [AW-1:0]       req_addr,
    input  logic                req_write,
    input  logic [BANK_W-1:0]   bank,
    input  logic [AW-1:0]       sp,
    output target_e             tgt,
    output logic [AW-1:0]       byte_addr,
    output logic                is_bit,
    output logic [REGIDX_W-1:0] bit_pos,
    output logic                op_rd,
    output logic                op_wr,
    output logic                do_push,
    output logic                do_pop
);

    localparam int PAD_W  = AW - BANK_W - REGIDX_W;
    localparam int BYTE_W = AW - 1 - REGIDX_W;

    kind_e kind;
    target_e tgt_raw;

    assign kind = kind_e'(req_kind);

    always_comb begin
        tgt_raw   = T_NONE;
        byte_addr = req_addr;
        is_bit    = 1'b0;
        op_wr     = 1'b0;
        unique case (kind)
            K_REG: begin
                tgt_raw   = T_RAM;
                byte_addr = {{PAD_W{1'b0}}, bank, req_addr[REGIDX_W-1:0]};
                op_wr     = req_write;
            end
            K_DIR: begin
                if (!req_addr[AW-1])          tgt_raw = T_RAM;
                else if (req_addr == SP_SFR)  tgt_raw = T_SP;
                else                          tgt_raw = T_SFR;
                op_wr = req_write;
            end
            K_IND: begin
                tgt_raw = T_RAM;
                op_wr   = req_write;
            end
            K_BIT: begin
                is_bit = 1'b1;
                op_wr  = req_write;
                if (!req_addr[AW-1]) begin
                    tgt_raw   = T_RAM;
                    byte_addr = AW'(BIT_BASE) + AW'(req_addr[AW-2:REGIDX_W]);
                end else begin
                    tgt_raw   = T_SFR;
                    byte_addr = {req_addr[AW-1:REGIDX_W], {REGIDX_W{1'b0}}};
                end
            end
            K_PUSH: begin
                tgt_raw   = T_RAM;
                byte_addr = sp + AW'(1);
                op_wr     = 1'b1;
            end
            K_POP: begin
                tgt_raw   = T_RAM;
                byte_addr = sp;
            end
            default: begin
                tgt_raw = T_NONE;
            end
        endcase
    end

    assign tgt     = req_valid ? tgt_raw : T_NONE;
    assign bit_pos = req_addr[REGIDX_W-1:0];
    assign op_rd   = (tgt != T_NONE) && (!op_wr || is_bit);
    assign do_push = (tgt == T_RAM) && (kind == K_PUSH);
    assign do_pop  = (tgt == T_RAM) && (kind == K_POP);

    localparam int UNUSED_BYTE_W = BYTE_W;

endmodule

// File: rtl/idm_bitmerge.sv
module idm_bitmerge #(
    parameter int DW    = 8,
    parameter int POS_W = $clog2(DW)
) (
    input  logic [DW-1:0]    byte_in,
    input  logic [POS_W-1:0] bit_pos,
    input  logic             bit_val,
    output logic             bit_out,
    output logic [DW-1:0]    byte_out
);

    for (genvar i = 0; i < DW; i++) begin : g_lane
        assign byte_out[i] = (bit_pos == POS_W'(i)) ? bit_val : byte_in[i];
    end

    assign bit_out = byte_in[bit_pos];

endmodule

// File: rtl/idm_ctxregs.sv
module idm_ctxregs #(
    parameter int          AW       = 8,
    parameter int          BANK_W   = 2,
    parameter logic [7:0]  SP_RESET = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_load,
    input  logic [BANK_W-1:0] bank_val,
    input  logic              sp_load,
    input  logic [AW-1:0]     sp_val,
    input  logic              push,
    input  logic              pop,
    output logic [AW-1:0]     sp_q,
    output logic [BANK_W-1:0] bank_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (bank_load) begin
            bank_q <= bank_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= AW'(SP_RESET);
        end else if (sp_load) begin
            sp_q <= sp_val;
        end else if (push) begin
            sp_q <= sp_q + AW'(1);
        end else if (pop) begin
            sp_q <= sp_q - AW'(1);
        end
    end

endmodule

// File: rtl/idm_mapper.sv
module idm_mapper
    import idm_pkg::*;
#(
    parameter int          AW       = 8,
    parameter int          DW       = 8,
    parameter int          BANK_W   = 2,
    parameter int          REGIDX_W = 3,
    parameter logic [7:0]  BIT_BASE = 8'h20,
    parameter logic [7:0]  SP_SFR   = 8'h81,
    parameter logic [7:0]  SP_RESET = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_write,
    input  logic [DW-1:0]     req_wdata,
    input  logic              bank_load,
    input  logic [BANK_W-1:0] bank_val,
    output logic [DW-1:0]     rd_data,
    output logic [AW-1:0]     ram_addr,
    output logic              ram_re,
    output logic              ram_we,
    output logic [DW-1:0]     ram_wdata,
    input  logic [DW-1:0]     ram_rdata,
    output logic [AW-1:0]     sfr_addr,
    output logic              sfr_re,
    output logic              sfr_we,
    output logic [DW-1:0]     sfr_wdata,
    input  logic [DW-1:0]     sfr_rdata,
    output logic [AW-1:0]     sp,
    output logic [BANK_W-1:0] bank
);

    target_e             tgt;
    logic [AW-1:0]       byte_addr;
    logic                is_bit;
    logic [REGIDX_W-1:0] bit_pos;
    logic                op_rd;
    logic                op_wr;
    logic                do_push;
    logic                do_pop;
    logic [DW-1:0]       src_byte;
    logic [DW-1:0]       merged;
    logic                bit_out;
    logic [DW-1:0]       out_byte;

    idm_decode #(
        .AW       (AW),
        .BANK_W   (BANK_W),
        .REGIDX_W (REGIDX_W),
        .BIT_BASE (BIT_BASE),
        .SP_SFR   (SP_SFR)
    ) u_decode (
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_write (req_write),
        .bank      (bank),
        .sp        (sp),
        .tgt       (tgt),
        .byte_addr (byte_addr),
        .is_bit    (is_bit),
        .bit_pos   (bit_pos),
        .op_rd     (op_rd),
        .op_wr     (op_wr),
        .do_push   (do_push),
        .do_pop    (do_pop)
    );

    assign src_byte = (tgt == T_SFR) ? sfr_rdata : ram_rdata;

    idm_bitmerge #(
        .DW    (DW),
        .POS_W (REGIDX_W)
    ) u_merge (
        .byte_in  (src_byte),
        .bit_pos  (bit_pos),
        .bit_val  (req_wdata[0]),
        .bit_out  (bit_out),
        .byte_out (merged)
    );

    idm_ctxregs #(
        .AW       (AW),
        .BANK_W   (BANK_W),
        .SP_RESET (SP_RESET)
    ) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_load (bank_load),
        .bank_val  (bank_val),
        .sp_load   ((tgt == T_SP) && op_wr),
        .sp_val    (req_wdata[AW-1:0]),
        .push      (do_push),
        .pop       (do_pop),
        .sp_q      (sp),
        .bank_q    (bank)
    );

    assign out_byte  = is_bit ? merged : req_wdata;

    assign ram_addr  = byte_addr;
    assign ram_re    = (tgt == T_RAM) && op_rd;
    assign ram_we    = (tgt == T_RAM) && op_wr;
    assign ram_wdata = out_byte;

    assign sfr_addr  = byte_addr;
    assign sfr_re    = (tgt == T_SFR) && op_rd;
    assign sfr_we    = (tgt == T_SFR) && op_wr;
    assign sfr_wdata = out_byte;

    always_comb begin
        rd_data = '0;
        if (is_bit && (tgt != T_NONE)) begin
            rd_data = {{(DW-1){1'b0}}, bit_out};
        end else begin
            unique case (tgt)
                T_RAM:   rd_data = ram_rdata;
                T_SFR:   rd_data = sfr_rdata;
                T_SP:    rd_data = DW'(sp);
                default: rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/idm_mapper_chk.sv
module idm_mapper_chk
    import idm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_kind,
    input logic [7:0] req_addr,
    input logic       req_write,
    input logic       ram_re,
    input logic       ram_we,
    input logic [7:0] ram_rdata,
    input logic [7:0] ram_wdata,
    input logic       sfr_re,
    input logic       sfr_we,
    input logic [7:0] sp
);

    logic ram_any;
    logic sfr_any;
    assign ram_any = ram_re || ram_we;
    assign sfr_any = sfr_re || sfr_we;

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_kind == 3'd6 || req_kind == 3'd7) |-> (!ram_any && !sfr_any));

    a_r12_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(sp));

    a_r4_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_any && sfr_any));

    a_r6_ind_no_sfr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == K_IND) |-> (ram_any && !sfr_any));

    a_r8_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == K_BIT && req_write && !req_addr[7])
            |-> (ram_re && ram_we && $countones(ram_wdata ^ ram_rdata) <= 1));

    a_r10_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == K_PUSH) |=> (sp == $past(sp) + 8'd1));

    a_r11_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == K_POP) |=> (sp == $past(sp) - 8'd1));

endmodule

bind idm_mapper idm_mapper_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_write (req_write),
    .ram_re    (ram_re),
    .ram_we    (ram_we),
    .ram_rdata (ram_rdata),
    .ram_wdata (ram_wdata),
    .sfr_re    (sfr_re),
    .sfr_we    (sfr_we),
    .sp        (sp)
);

// File: tb/idm_mapper_bench.sv
module idm_mapper_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_kind = '0;
    logic [7:0] req_addr = '0;
    logic       req_write = 1'b0;
    logic [7:0] req_wdata = '0;
    logic       bank_load = 1'b0;
    logic [1:0] bank_val = '0;
    logic [7:0] rd_data, ram_addr, ram_wdata, ram_rdata;
    logic [7:0] sfr_addr, sfr_wdata, sfr_rdata, sp;
    logic       ram_re, ram_we, sfr_re, sfr_we;
    logic [1:0] bank;

    logic [7:0] mem [256];
    logic [7:0] sfr [256];

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    assign ram_rdata = mem[ram_addr];
    assign sfr_rdata = sfr[sfr_addr];

    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (sfr_we) sfr[sfr_addr] <= sfr_wdata;
    end

    idm_mapper u_idm_mapper (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .bank_load(bank_load), .bank_val(bank_val), .rd_data(rd_data),
        .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .sfr_addr(sfr_addr),
        .sfr_re(sfr_re), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .sp(sp), .bank(bank)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] k, input logic [7:0] a, input logic w, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_write = w; req_wdata = d;
        #1;
    endtask

    task automatic quiet();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        #1;
    endtask

    function automatic logic [3:0] strobes();
        return {ram_re, ram_we, sfr_re, sfr_we};
    endfunction

    task automatic t_reset();
        check("R1 sp after reset", 16'(sp), 16'h07);
        check("R1 bank after reset", 16'(bank), 16'h0);
        check("R1 strobes idle", 16'(strobes()), 16'h0);
    endtask

    task automatic t_stack();
        issue(3'd4, 8'h00, 1'b0, 8'h5A);
        check("R10 push addr", 16'(ram_addr), 16'h08);
        check("R10 push we", 16'(strobes()), 16'b0100);
        issue(3'd4, 8'h00, 1'b0, 8'h6B);
        check("R10 sp after first push", 16'(sp), 16'h08);
        check("R10 second push addr", 16'(ram_addr), 16'h09);
        issue(3'd5, 8'h00, 1'b0, 8'h00);
        check("R11 pop addr", 16'(ram_addr), 16'h09);
        check("R11 pop data", 16'(rd_data), 16'h6B);
        quiet();
        check("R11 sp after pop", 16'(sp), 16'h08);
        check("R10 first push stored", 16'(mem[8'h08]), 16'h5A);
        issue(3'd1, 8'h81, 1'b1, 8'hFF);
        issue(3'd4, 8'h00, 1'b0, 8'hC3);
        check("R10 wrap addr", 16'(ram_addr), 16'h00);
        quiet();
        check("R10 wrap sp", 16'(sp), 16'h00);
        check("R10 wrap stored", 16'(mem[8'h00]), 16'hC3);
    endtask

    task automatic t_regs();
        @(negedge clk);
        bank_load = 1'b1; bank_val = 2'd3;
        @(negedge clk);
        bank_load = 1'b0;
        mem[8'h1C] = 8'hA5;
        issue(3'd0, 8'h04, 1'b0, 8'h00);
        check("R2 bank3 R4 addr", 16'(ram_addr), 16'h1C);
        check("R2 bank3 R4 data", 16'(rd_data), 16'hA5);
        @(negedge clk);
        bank_load = 1'b1; bank_val = 2'd0;
        issue(3'd0, 8'h07, 1'b1, 8'h3C);
        bank_load = 1'b0;
        check("R2 bank0 R7 addr", 16'(ram_addr), 16'h07);
        quiet();
        check("R2 bank0 R7 stored", 16'(mem[8'h07]), 16'h3C);
    endtask

    task automatic t_direct();
        mem[8'h45] = 8'h12;
        issue(3'd1, 8'h45, 1'b0, 8'h00);
        check("R3 low direct strobes", 16'(strobes()), 16'b1000);
        check("R3 low direct data", 16'(rd_data), 16'h12);
        sfr[8'h90] = 8'h77;
        issue(3'd1, 8'h90, 1'b0, 8'h00);
        check("R4 high direct strobes", 16'(strobes()), 16'b0010);
        check("R4 high direct addr", 16'(sfr_addr), 16'h90);
        check("R4 high direct data", 16'(rd_data), 16'h77);
        issue(3'd1, 8'hA8, 1'b1, 8'h11);
        quiet();
        check("R4 sfr write stored", 16'(sfr[8'hA8]), 16'h11);
        issue(3'd1, 8'h81, 1'b1, 8'h30);
        check("R5 sp write no strobe", 16'(strobes()), 16'h0);
        issue(3'd1, 8'h81, 1'b0, 8'h00);
        check("R5 sp read back", 16'(rd_data), 16'h30);
        check("R5 sp read no strobe", 16'(strobes()), 16'h0);
        quiet();
    endtask

    task automatic t_indirect();
        mem[8'h90] = 8'h9E;
        issue(3'd2, 8'h90, 1'b0, 8'h00);
        check("R6 indirect strobes", 16'(strobes()), 16'b1000);
        check("R6 indirect data", 16'(rd_data), 16'h9E);
        issue(3'd2, 8'hF0, 1'b1, 8'h5C);
        quiet();
        check("R6 indirect high stored", 16'(mem[8'hF0]), 16'h5C);
    endtask

    task automatic t_bit_ram();
        mem[8'h25] = 8'h81;
        issue(3'd3, 8'h2B, 1'b1, 8'h01);
        check("R7 bit byte addr", 16'(ram_addr), 16'h25);
        check("R8 rmw strobes", 16'(strobes()), 16'b1100);
        quiet();
        check("R8 bit set merged", 16'(mem[8'h25]), 16'h89);
        @(negedge clk);
        mem[8'h20] = 8'hFF;
        issue(3'd3, 8'h05, 1'b0, 8'h00);
        check("R7 bit read one", 16'(rd_data), 16'h01);
        issue(3'd3, 8'h02, 1'b1, 8'h00);
        quiet();
        check("R8 bit clear merged", 16'(mem[8'h20]), 16'hFB);
        issue(3'd3, 8'h02, 1'b0, 8'h00);
        check("R7 bit read zero", 16'(rd_data), 16'h00);
        quiet();
    endtask

    task automatic t_bit_sfr();
        sfr[8'hD0] = 8'h41;
        issue(3'd3, 8'hD4, 1'b1, 8'h01);
        check("R9 sfr bit addr", 16'(sfr_addr), 16'hD0);
        check("R9 sfr rmw strobes", 16'(strobes()), 16'b0011);
        quiet();
        check("R9 sfr bit merged", 16'(sfr[8'hD0]), 16'h51);
        issue(3'd3, 8'hD6, 1'b0, 8'h00);
        check("R9 sfr bit read", 16'(rd_data), 16'h01);
        quiet();
    endtask

    task automatic t_ignored();
        logic [7:0] sp0;
        sp0 = sp;
        issue(3'd6, 8'h10, 1'b1, 8'hEE);
        check("R12 kind6 strobes", 16'(strobes()), 16'h0);
        issue(3'd7, 8'h10, 1'b1, 8'hEE);
        check("R12 kind7 strobes", 16'(strobes()), 16'h0);
        @(negedge clk);
        req_valid = 1'b0; req_kind = 3'd4; req_wdata = 8'hEE;
        #1;
        check("R12 invalid push strobes", 16'(strobes()), 16'h0);
        @(negedge clk);
        #1;
        check("R12 sp unchanged", 16'(sp), 16'(sp0));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'h00;
            sfr[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_stack();
        t_regs();
        t_direct();
        t_indirect();
        t_bit_ram();
        t_bit_sfr();
        t_ignored();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule